// File: doc/BRIEF.md
# Undervoltage Fault Response Sequencer

This block decides what a power stage does when an output undervoltage condition is reported. A host programs one configuration byte through a small write/read register port. The byte has three fields. The top two bits choose the reaction: keep running, shut down after a delay counted in PWM clock ticks, or shut down at once. The middle three bits set how many restart attempts are allowed, and one code means retry without limit. The low three bits set the delay length and the hiccup wait. The hiccup wait is a whole multiple of the soft-start rise time.

After a shutdown with restart attempts left, the stage stays off for one hiccup period and then starts again. When no attempts remain, the block latches off. The enable command must then be dropped and raised again. A soft-start that finishes with no fault present clears the count of attempts used. If a host write carries the unsupported reaction encoding, the block rejects it and raises an invalid-data flag.

Top module: `uv_fault_seq`

## Requirements
- R1: After reset the configuration reads 0x80, and the stage enable, the latched status and the invalid flag are all low.
- R2: A write whose bits 7:6 are not 11 is stored. The next cycle it reads back unchanged and the invalid flag is low.
- R3: A write whose bits 7:6 are 11 is rejected. The stored byte stays the same and the invalid flag is high from the next cycle.
- R4: When the enable command is high and the block is not latched off, the stage enable rises one cycle later. When the enable command is low, the stage enable and the latched status are both low one cycle later.
- R5: With bits 7:6 = 00 (ignore), the fault input never lowers the stage enable.
- R6: With bits 7:6 = 10 (immediate), a fault sampled while running makes the stage enable low in the next cycle.
- R7: With bits 7:6 = 01 (delayed), shutdown occurs in the cycle after the D-th PWM tick sampled with the fault continuously present. D is 1 for bits 2:0 = 0 or 1, 3 for codes 2 to 4, and 7 for codes 5 to 7. Cycles without a tick do not advance the delay.
- R8: In delayed mode, a cycle with the fault absent restarts the delay count from zero.
- R9: After a shutdown that is followed by a restart, the stage enable stays low for H ticks and rises in the cycle after the H-th tick. H is the rise time multiplied by bits 2:0, and codes 0 and 1 both count as 1.
- R10: Bits 5:3 set the retry limit. Code 0 latches off at the first shutdown. A code N from 1 to 6 allows N restarts and latches off at shutdown N+1. Code 7 never latches off.
- R11: A soft-start-complete indication with no fault present, while running, resets the count of restart attempts used.
- R12: While latched, the stage enable stays low and the latched status stays high for as long as the enable command is high. A low then high on the enable command restarts the stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Stored configuration byte |
| pwm_tick | input | 1 | One-cycle PWM clock tick |
| uv_fault | input | 1 | Undervoltage condition present |
| ss_done | input | 1 | Soft-start has finished |
| en_cmd | input | 1 | Enable command |
| rise_ticks | input | RISE_W | Soft-start rise time in ticks |
| stage_en | output | 1 | Power-stage enable |
| latched | output | 1 | Latched-off status |
| invalid_flag | output | 1 | Last write was rejected |

## Verification
The bench builds the block with RISE_W = 4. With this width, every rise time used, from 1 to 3 ticks, combined with every timing code, gives a hiccup wait of at most 21 ticks. That makes a full cross of the rise time and the timing code cheap. All 256 write values are swept against a shadow copy, and all eight delay codes and all eight retry codes are walked, so each encoding boundary is reached directly.

// File: rtl/uv_pkg.sv
// Package: shared types and code decoders for the undervoltage sequencer.
// Assumes the configuration byte layout {mode[1:0], retry[2:0], tcode[2:0]}.
package uv_pkg;

    typedef enum logic [1:0] {
        MODE_IGNORE    = 2'b00,
        MODE_DELAYED   = 2'b01,
        MODE_IMMEDIATE = 2'b10,
        MODE_BAD       = 2'b11
    } uv_mode_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_RUN,
        ST_HICCUP,
        ST_LATCH
    } uv_state_e;

    typedef struct packed {
        uv_mode_e   mode;
        logic [2:0] retry;
        logic [2:0] tcode;
    } uv_cfg_t;

    localparam logic [7:0] CFG_RESET     = 8'h80;
    localparam logic [2:0] RETRY_FOREVER = 3'd7;

    // Delay length in ticks for a timing code: 1, 3 or 7.
    function automatic logic [2:0] delay_ticks(input logic [2:0] code);
        if (code <= 3'd1)      return 3'd1;
        else if (code <= 3'd4) return 3'd3;
        else                   return 3'd7;
    endfunction

    // Hiccup multiplier of the rise time: codes 0 and 1 both give 1.
    function automatic logic [2:0] hiccup_mult(input logic [2:0] code);
        return (code == 3'd0) ? 3'd1 : code;
    endfunction

endpackage

// File: rtl/uv_cfg_reg.sv
// Configuration register: stores the host byte, rejects the unsupported
// mode encoding and flags the rejection. Assumes single-cycle write strobes.
module uv_cfg_reg
    import uv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output uv_cfg_t    cfg,
    output logic       invalid
);

    logic [7:0] store_q;
    logic       bad_q;
    logic       wr_bad;

    // Decode whether the incoming byte uses the unsupported mode.
    always_comb begin
        wr_bad = (wdata[7:6] == MODE_BAD);
    end

    // Store valid writes and keep the rejection flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= CFG_RESET;
            bad_q   <= 1'b0;
        end else if (wr) begin
            bad_q <= wr_bad;
            if (!wr_bad) begin
                store_q <= wdata;
            end
        end
    end

    assign rdata   = store_q;
    assign cfg     = uv_cfg_t'(store_q);
    assign invalid = bad_q;

endmodule

// File: rtl/uv_tick_counter.sv
// Shared tick counter: used as the delay counter while running and as the
// hiccup counter while off. Saturates at all ones; clear wins over count.
module uv_tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_q;

    // Clear, or advance one step without wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/uv_seq_fsm.sv
// Sequencer state machine: runs the stage, applies the fault reaction,
// waits out hiccup periods, tracks restart attempts and latches off.
// Assumes the counter it drives is cleared on every state change.
module uv_seq_fsm
    import uv_pkg::*;
#(
    parameter int RISE_W = 16,
    parameter int CNT_W  = RISE_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  uv_cfg_t           cfg,
    input  logic              tick,
    input  logic              fault,
    input  logic              ss_done,
    input  logic              en_cmd,
    input  logic [RISE_W-1:0] rise_ticks,
    input  logic [CNT_W-1:0]  count,
    output logic              cnt_clr,
    output logic              cnt_inc,
    output logic              stage_en,
    output logic              latched
);

    localparam int CMP_W = CNT_W + 1;

    uv_state_e       state_q, state_d;
    logic [2:0]      tries_q, tries_d;
    logic [CMP_W-1:0] count_next;
    logic [CMP_W-1:0] delay_lim;
    logic [CMP_W-1:0] hiccup_lim;
    logic            delay_done;
    logic            hiccup_done;
    logic            shut_req;
    logic            give_up;
    logic            success;

    // Compare limits for the delay and hiccup windows.
    always_comb begin
        count_next  = {1'b0, count} + 1'b1;
        delay_lim   = CMP_W'(delay_ticks(cfg.tcode));
        hiccup_lim  = CMP_W'(rise_ticks) * CMP_W'(hiccup_mult(cfg.tcode));
        delay_done  = tick && (count_next >= delay_lim);
        hiccup_done = tick && (count_next >= hiccup_lim);
    end

    // Decide whether a shutdown is due and whether retries are spent.
    always_comb begin
        unique case (cfg.mode)
            MODE_IMMEDIATE: shut_req = fault;
            MODE_DELAYED:   shut_req = fault && delay_done;
            default:        shut_req = 1'b0;
        endcase
        give_up = (cfg.retry == 3'd0) ||
                  ((cfg.retry != RETRY_FOREVER) && (tries_q >= cfg.retry));
        success = ss_done && !fault;
    end

    // Next-state and attempt-count logic.
    always_comb begin
        state_d = state_q;
        tries_d = tries_q;
        unique case (state_q)
            ST_OFF: begin
                tries_d = 3'd0;
                if (en_cmd) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!en_cmd) begin
                    state_d = ST_OFF;
                end else if (shut_req) begin
                    if (give_up) begin
                        state_d = ST_LATCH;
                    end else begin
                        state_d = ST_HICCUP;
                        if (cfg.retry != RETRY_FOREVER) tries_d = tries_q + 3'd1;
                    end
                end else if (success) begin
                    tries_d = 3'd0;
                end
            end
            ST_HICCUP: begin
                if (!en_cmd)          state_d = ST_OFF;
                else if (hiccup_done) state_d = ST_RUN;
            end
            default: begin
                if (!en_cmd) state_d = ST_OFF;
            end
        endcase
    end

    // Counter control: count delay ticks under fault, or hiccup ticks.
    always_comb begin
        cnt_inc = tick && (((state_q == ST_RUN) && fault && (cfg.mode == MODE_DELAYED)) ||
                           (state_q == ST_HICCUP));
        cnt_clr = (state_d != state_q) || ((state_q == ST_RUN) && !fault);
    end

    // State and attempt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            tries_q <= 3'd0;
        end else begin
            state_q <= state_d;
            tries_q <= tries_d;
        end
    end

    assign stage_en = (state_q == ST_RUN);
    assign latched  = (state_q == ST_LATCH);

endmodule

// File: rtl/uv_fault_seq.sv
// Top level: configuration register, shared tick counter and sequencer.
// Assumes pwm_tick is a one-cycle pulse and all inputs are synchronous.
module uv_fault_seq
    import uv_pkg::*;
#(
    parameter int RISE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              pwm_tick,
    input  logic              uv_fault,
    input  logic              ss_done,
    input  logic              en_cmd,
    input  logic [RISE_W-1:0] rise_ticks,
    output logic              stage_en,
    output logic              latched,
    output logic              invalid_flag
);

    localparam int CNT_W = RISE_W + 3;

    uv_cfg_t          cfg;
    logic             cnt_clr;
    logic             cnt_inc;
    logic [CNT_W-1:0] count;

    uv_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .cfg     (cfg),
        .invalid (invalid_flag)
    );

    uv_tick_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (count)
    );

    uv_seq_fsm #(.RISE_W(RISE_W), .CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .tick       (pwm_tick),
        .fault      (uv_fault),
        .ss_done    (ss_done),
        .en_cmd     (en_cmd),
        .rise_ticks (rise_ticks),
        .count      (count),
        .cnt_clr    (cnt_clr),
        .cnt_inc    (cnt_inc),
        .stage_en   (stage_en),
        .latched    (latched)
    );

endmodule

// File: rtl/uv_fault_seq_chk.sv
// Checker: port-level properties of the sequencer, bound to the top.
module uv_fault_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_rdata,
    input logic       uv_fault,
    input logic       en_cmd,
    input logic       stage_en,
    input logic       latched,
    input logic       invalid_flag
);

    assert_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[7:6] != 2'b11) |=> (cfg_rdata == $past(cfg_wdata)) && !invalid_flag);

    assert_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[7:6] == 2'b11) |=> invalid_flag && $stable(cfg_rdata));

    assert_disable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en_cmd |=> !stage_en && !latched);

    assert_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[7:6] == 2'b00 && stage_en && en_cmd && !cfg_wr) |=> stage_en);

    assert_immediate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[7:6] == 2'b10 && stage_en && en_cmd && uv_fault) |=> !stage_en);

    assert_latch_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (latched && en_cmd) |=> latched && !stage_en);

endmodule

bind uv_fault_seq uv_fault_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .uv_fault     (uv_fault),
    .en_cmd       (en_cmd),
    .stage_en     (stage_en),
    .latched      (latched),
    .invalid_flag (invalid_flag)
);

// File: tb/uv_fault_seq_tb.sv
module uv_fault_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int RISE_W     = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [7:0]        cfg_wdata = 8'h00;
    logic [7:0]        cfg_rdata;
    logic              pwm_tick = 1'b1;
    logic              uv_fault = 1'b0;
    logic              ss_done = 1'b0;
    logic              en_cmd = 1'b0;
    logic [RISE_W-1:0] rise_ticks = 4'd1;
    logic              stage_en;
    logic              latched;
    logic              invalid_flag;

    int n_checks = 0;
    int n_fail   = 0;

    uv_fault_seq #(.RISE_W(RISE_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr       (cfg_wr),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .pwm_tick     (pwm_tick),
        .uv_fault     (uv_fault),
        .ss_done      (ss_done),
        .en_cmd       (en_cmd),
        .rise_ticks   (rise_ticks),
        .stage_en     (stage_en),
        .latched      (latched),
        .invalid_flag (invalid_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        cfg_wr = 1'b1;
        cfg_wdata = v;
        step();
        cfg_wr = 1'b0;
    endtask

    task automatic go_off();
        uv_fault = 1'b0;
        ss_done = 1'b0;
        en_cmd = 1'b0;
        step();
    endtask

    function automatic int exp_delay(input int c);
        return (c <= 1) ? 1 : (c <= 4) ? 3 : 7;
    endfunction

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] shadow;
        bit         inv_exp;
        bit         ok;

        step(); step();
        // R1: reset state
        chk(cfg_rdata == 8'h80, "R1 cfg", cfg_rdata, 8'h80);
        chk(!stage_en && !latched && !invalid_flag, "R1 outputs",
            {stage_en, latched, invalid_flag}, 0);
        rst_n = 1'b1;
        step();

        // R2 / R3: sweep all write values against a shadow copy
        shadow = 8'h80;
        for (int v = 0; v < 256; v++) begin
            write_cfg(v[7:0]);
            inv_exp = (v[7:6] == 2'b11);
            if (!inv_exp) shadow = v[7:0];
            chk(cfg_rdata == shadow, inv_exp ? "R3 byte kept" : "R2 readback", cfg_rdata, shadow);
            chk(invalid_flag == inv_exp, inv_exp ? "R3 flag" : "R2 flag", invalid_flag, inv_exp);
        end
        write_cfg(8'h80);

        // R4: enable follows command one cycle later
        en_cmd = 1'b1; step();
        chk(stage_en == 1'b1, "R4 enable on", stage_en, 1);
        en_cmd = 1'b0; step();
        chk(stage_en == 1'b0, "R4 enable off", stage_en, 0);

        // R5: ignore mode is unaffected by the fault
        write_cfg(8'b00_000_111);
        en_cmd = 1'b1; step();
        uv_fault = 1'b1;
        ok = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step();
            if (!stage_en) ok = 1'b0;
        end
        chk(ok, "R5 ignore keeps stage on", ok, 1);
        go_off();

        // R6 / R10 code 0 / R12: immediate shutdown, latch, restart
        write_cfg(8'h80);
        en_cmd = 1'b1; step();
        uv_fault = 1'b1; step();
        chk(stage_en == 1'b0, "R6 immediate shutdown", stage_en, 0);
        chk(latched == 1'b1, "R10 retry 0 latches", latched, 1);
        uv_fault = 1'b0;
        repeat (10) step();
        chk(latched && !stage_en, "R12 latch holds", {latched, stage_en}, 2);
        en_cmd = 1'b0; step();
        chk(!latched, "R12 latch cleared by low enable", latched, 0);
        en_cmd = 1'b1; step();
        chk(stage_en, "R12 restart after toggle", stage_en, 1);
        go_off();

        // R7: delayed shutdown for each timing code
        for (int c = 0; c < 8; c++) begin
            int d;
            d = exp_delay(c);
            write_cfg({2'b01, 3'b000, c[2:0]});
            en_cmd = 1'b1; step();
            uv_fault = 1'b1;
            repeat (d - 1) step();
            chk(stage_en == 1'b1, "R7 before delay end", stage_en, 1);
            step();
            chk(stage_en == 1'b0 && latched, "R7 shutdown at delay end", stage_en, 0);
            go_off();
        end

        // R7: no tick, no progress
        write_cfg(8'b01_000_000);
        en_cmd = 1'b1; step();
        pwm_tick = 1'b0;
        uv_fault = 1'b1;
        repeat (10) step();
        chk(stage_en == 1'b1, "R7 no tick no shutdown", stage_en, 1);
        pwm_tick = 1'b1;
        step();
        chk(stage_en == 1'b0, "R7 first tick shuts down", stage_en, 0);
        go_off();

        // R8: a fault gap restarts the delay
        write_cfg(8'b01_000_111);
        en_cmd = 1'b1; step();
        uv_fault = 1'b1; repeat (5) step();
        uv_fault = 1'b0; step();
        uv_fault = 1'b1; repeat (6) step();
        chk(stage_en == 1'b1, "R8 count restarted", stage_en, 1);
        step();
        chk(stage_en == 1'b0, "R8 shutdown after full delay", stage_en, 0);
        go_off();

        // R9: hiccup length across rise times and timing codes
        for (int r = 1; r <= 3; r++) begin
            for (int c = 0; c < 8; c++) begin
                int h;
                h = r * ((c == 0) ? 1 : c);
                rise_ticks = r[RISE_W-1:0];
                write_cfg({2'b10, 3'b111, c[2:0]});
                en_cmd = 1'b1; step();
                uv_fault = 1'b1; step();
                uv_fault = 1'b0;
                chk(stage_en == 1'b0, "R9 off after shutdown", stage_en, 0);
                repeat (h - 1) step();
                chk(stage_en == 1'b0, "R9 off during hiccup", stage_en, 0);
                step();
                chk(stage_en == 1'b1, "R9 restart after hiccup", stage_en, 1);
                go_off();
            end
        end

        // R10: retry limit for codes 1 to 7
        rise_ticks = 4'd1;
        for (int r = 1; r < 8; r++) begin
            int last;
            last = (r == 7) ? 10 : r;
            write_cfg({2'b10, r[2:0], 3'b000});
            en_cmd = 1'b1; step();
            for (int k = 0; k <= last; k++) begin
                uv_fault = 1'b1; step();
                uv_fault = 1'b0;
                if (r == 7 || k < r) begin
                    chk(!latched, "R10 retry left", latched, 0);
                    step();
                    chk(stage_en, "R10 restarted", stage_en, 1);
                end else begin
                    chk(latched, "R10 limit reached", latched, 1);
                end
            end
            go_off();
        end

        // R11: successful start-up clears the attempts used
        write_cfg(8'b10_001_000);
        en_cmd = 1'b1; step();
        uv_fault = 1'b1; step(); uv_fault = 1'b0; step();
        ss_done = 1'b1; step(); ss_done = 1'b0;
        uv_fault = 1'b1; step(); uv_fault = 1'b0;
        chk(!latched, "R11 attempts cleared", latched, 0);
        step();
        chk(stage_en, "R11 restarted", stage_en, 1);
        uv_fault = 1'b1; step(); uv_fault = 1'b0;
        chk(latched, "R11 latches without success", latched, 1);
        go_off();

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule